// File: doc/BRIEF.md
# Cache Peripheral Sleep Controller

This controller drives the sleep signal for the peripheral circuits of a large cache. These circuits include the wordline drivers, the decoders and the address and data drivers. It can follow either of two policies, and the policy is picked at run time.

In the access-driven policy the peripherals are held asleep by default. A cache access wakes them, and they stay awake for a programmable hold window. Each further access restarts that window.

In the stall-driven policy the peripherals are awake by default. They go to sleep only while a miss is outstanding and the core has shown no issue and no execute activity for a programmable number of consecutive cycles. They wake again a programmable lead time before the miss returns, so the refill finds them ready.

An access that arrives while the peripherals sleep raises a wake-pending flag. The flag lasts a fixed number of cycles and tells the requester to stall. The hold window, the idle threshold and the lead time are each loaded through a small configuration port.

Top module: `cache_periph_sleep`

## Requirements
- R1: After reset, sleepOut is 1, wakePending is 0 and the access-driven policy is active. The hold window is 8, the idle threshold is 10 and the lead time is 4.
- R2: In the access-driven policy (modeSel=0), an access sampled at a clock edge clears sleepOut from that edge on. sleepOut stays 0 for exactly hold-window cycles and then returns to 1.
- R3: An access that arrives during the hold window reloads the window. sleepOut then stays 0 for a full hold window counted from the latest access.
- R4: In the stall-driven policy (modeSel=1), missStart marks a miss as outstanding. sleepOut rises at the edge where the consecutive idle count reaches the idle threshold, provided missRemain is above the lead time. With the default threshold, that edge is 10 edges after the missStart edge.
- R5: In the stall-driven policy, sleepOut is 0 after any edge where missRemain is at or below the lead time. A miss stops being outstanding at an edge where missRemain is 0, and without an outstanding miss sleepOut stays 0.
- R6: issueActive or execActive at an edge clears the consecutive idle count. In the stall-driven policy this clears sleepOut, and a new full threshold of idle cycles is needed before sleep returns.
- R7: An access sampled while sleepOut is 1 raises wakePending for WAKE_LAT cycles (default 1), starting at the next cycle. In the stall-driven policy an access also clears sleepOut and the idle count.
- R8: modeSel is latched only at edges where sleepOut is 0. A policy request made while asleep has no effect.
- R9: A write with cfgWrite=1 loads cfgData into one setting, chosen by cfgAddr: 0 is the hold window, 1 is the idle threshold and 2 is the lead time. cfgAddr=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accessStrobe | input | 1 | A cache access in this cycle |
| missStart | input | 1 | A new miss starts in this cycle |
| missRemain | input | CNT_W | Cycles left until the outstanding miss is serviced |
| issueActive | input | 1 | The issue logic issued an instruction in this cycle |
| execActive | input | 1 | A functional unit executed in this cycle |
| modeSel | input | 1 | Requested policy: 0 access-driven, 1 stall-driven |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Setting selected by a configuration write |
| cfgData | input | CNT_W | Value to load into the selected setting |
| sleepOut | output | 1 | Sleep request to the peripheral circuits |
| wakePending | output | 1 | Requester must stall while the peripherals wake |

## Verification
A wrong hold counter shows at the ports as an awake window that is too long or too short. It is seen at the edge where sleepOut should rise, at most one hold window after the access. A wrong idle counter or a wrong miss flag moves the sleepOut rising edge during a stall, or lets sleepOut rise without a miss. In both cases the error appears within one idle threshold of the last activity. A mode latched while asleep shows up at the next wake, because sleepOut then follows the wrong policy.

// File: rtl/sleepctl_pkg.sv
package sleepctl_pkg;
  typedef enum logic {MODE_ACCESS = 1'b0, MODE_MISS = 1'b1} modeE;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHold;
    logic loadWake;
    logic clrIdle;
  } ctlStrobeT;

  // status from datapath to control
  typedef struct packed {
    logic holdLive;
    logic idleMet;
    logic leadOk;
    logic missLive;
  } dpStatusT;
endpackage

// File: rtl/sleep_datapath.sv
module sleep_datapath
  import sleepctl_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int WAKE_LAT  = 1,
  parameter int HOLD_INIT = 8,
  parameter int IDLE_INIT = 10,
  parameter int LEAD_INIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrite,
  input  logic [1:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgData,
  input  logic             missStart,
  input  logic [CNT_W-1:0] missRemain,
  input  ctlStrobeT        strobe,
  output dpStatusT         status,
  output logic             wakePending,
  output logic [CNT_W-1:0] holdLen,
  output logic [CNT_W-1:0] leadLen
);
  localparam int WAKE_W = $clog2(WAKE_LAT + 1);
  localparam int NUM_CFG = 3;

  logic [CNT_W-1:0] cfgReg [NUM_CFG];
  logic [CNT_W-1:0] holdCnt, holdNext;
  logic [CNT_W-1:0] idleCnt, idleNext;
  logic [WAKE_W-1:0] wakeCnt;
  logic missOut;

  // configuration registers, one per setting
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    localparam logic [CNT_W-1:0] INIT =
      (g == 0) ? CNT_W'(HOLD_INIT) : (g == 1) ? CNT_W'(IDLE_INIT) : CNT_W'(LEAD_INIT);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cfgReg[g] <= INIT;
      else if (cfgWrite && cfgAddr == 2'(g)) cfgReg[g] <= cfgData;
    end
  end

  assign holdLen = cfgReg[0];
  assign leadLen = cfgReg[2];

  always_comb begin
    if (strobe.loadHold) holdNext = holdLen;
    else if (holdCnt != '0) holdNext = holdCnt - 1'b1;
    else holdNext = '0;

    if (!missOut || strobe.clrIdle) idleNext = '0;
    else if (idleCnt < cfgReg[1]) idleNext = idleCnt + 1'b1;
    else idleNext = idleCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
      idleCnt <= '0;
      wakeCnt <= '0;
      missOut <= 1'b0;
    end else begin
      holdCnt <= holdNext;
      idleCnt <= idleNext;
      if (strobe.loadWake) wakeCnt <= WAKE_W'(WAKE_LAT);
      else if (wakeCnt != '0) wakeCnt <= wakeCnt - 1'b1;
      if (missStart) missOut <= 1'b1;
      else if (missOut && missRemain == '0) missOut <= 1'b0;
    end
  end

  assign status.holdLive = (holdNext != '0);
  assign status.idleMet  = (idleNext >= cfgReg[1]);
  assign status.leadOk   = (missRemain > leadLen);
  assign status.missLive = missOut;
  assign wakePending     = (wakeCnt != '0);

  p_wake_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWake |=> wakePending);

  p_cfg_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrite && cfgAddr == 2'd3) |=> ($stable(holdLen) && $stable(leadLen)));
endmodule

// File: rtl/sleep_control.sv
module sleep_control
  import sleepctl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      accessStrobe,
  input  logic      issueActive,
  input  logic      execActive,
  input  logic      modeSel,
  input  dpStatusT  status,
  output ctlStrobeT strobe,
  output logic      sleepOut,
  output modeE      modeReg
);
  logic sleepNext;

  assign strobe.loadHold = accessStrobe;
  assign strobe.loadWake = accessStrobe && sleepOut;
  assign strobe.clrIdle  = accessStrobe || issueActive || execActive;

  always_comb begin
    unique case (modeReg)
      MODE_ACCESS: sleepNext = !status.holdLive;
      MODE_MISS:   sleepNext = status.missLive && status.idleMet && status.leadOk;
      default:     sleepNext = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepOut <= 1'b1;
      modeReg  <= MODE_ACCESS;
    end else begin
      sleepOut <= sleepNext;
      if (!sleepOut) modeReg <= modeE'(modeSel);
    end
  end

  p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    sleepOut |=> (modeReg == $past(modeReg)));

  p_activity_wakes_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_MISS && (issueActive || execActive)) |=> !sleepOut);
endmodule

// File: rtl/cache_periph_sleep.sv
module cache_periph_sleep
  import sleepctl_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int WAKE_LAT  = 1,
  parameter int HOLD_INIT = 8,
  parameter int IDLE_INIT = 10,
  parameter int LEAD_INIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accessStrobe,
  input  logic             missStart,
  input  logic [CNT_W-1:0] missRemain,
  input  logic             issueActive,
  input  logic             execActive,
  input  logic             modeSel,
  input  logic             cfgWrite,
  input  logic [1:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgData,
  output logic             sleepOut,
  output logic             wakePending
);
  ctlStrobeT strobe;
  dpStatusT  status;
  modeE      modeReg;
  logic [CNT_W-1:0] holdLen, leadLen;

  sleep_datapath #(
    .CNT_W(CNT_W), .WAKE_LAT(WAKE_LAT), .HOLD_INIT(HOLD_INIT),
    .IDLE_INIT(IDLE_INIT), .LEAD_INIT(LEAD_INIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .missStart(missStart), .missRemain(missRemain),
    .strobe(strobe), .status(status), .wakePending(wakePending),
    .holdLen(holdLen), .leadLen(leadLen)
  );

  sleep_control ctl_i (
    .clk(clk), .rstN(rstN), .accessStrobe(accessStrobe),
    .issueActive(issueActive), .execActive(execActive), .modeSel(modeSel),
    .status(status), .strobe(strobe), .sleepOut(sleepOut), .modeReg(modeReg)
  );

  p_access_wakes_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_ACCESS && accessStrobe && holdLen != '0) |=> !sleepOut);

  p_lead_wakes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_MISS && missRemain <= leadLen) |=> !sleepOut);

  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (sleepOut && !wakePending));
endmodule

// File: tb/cache_periph_sleep_tb_top.sv
`timescale 1ns/1ps
module cache_periph_sleep_tb_top;
  localparam int CNT_W = 16;
  localparam int WAKE_LAT = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accessStrobe = 0, missStart = 0, issueActive = 0, execActive = 0;
  logic modeSel = 0, cfgWrite = 0;
  logic [1:0] cfgAddr = '0;
  logic [CNT_W-1:0] cfgData = '0, missRemain = '0;
  logic sleepOut, wakePending;

  int checks = 0, errors = 0;
  bit finished = 0;
  string curTag = "R1";

  always #2.5 clk = ~clk;

  cache_periph_sleep #(.CNT_W(CNT_W), .WAKE_LAT(WAKE_LAT)) dut_i (
    .clk(clk), .rstN(rstN), .accessStrobe(accessStrobe), .missStart(missStart),
    .missRemain(missRemain), .issueActive(issueActive), .execActive(execActive),
    .modeSel(modeSel), .cfgWrite(cfgWrite), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .sleepOut(sleepOut), .wakePending(wakePending)
  );

  // reference model written from the requirements
  logic mMode, mSleep, mMiss;
  int mHold, mIdle, mWake, mJ, mK, mM;

  function automatic int nextHold(bit acc, int hold, int j);
    if (acc) return j;
    return (hold > 0) ? hold - 1 : 0;
  endfunction

  function automatic int nextIdle(bit miss, bit act, int idle, int k);
    if (!miss || act) return 0;
    return (idle < k) ? idle + 1 : idle;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode <= 0; mSleep <= 1; mMiss <= 0;
      mHold <= 0; mIdle <= 0; mWake <= 0;
      mJ <= 8; mK <= 10; mM <= 4;
    end else begin
      int hN, iN;
      hN = nextHold(accessStrobe, mHold, mJ);
      iN = nextIdle(mMiss, accessStrobe || issueActive || execActive, mIdle, mK);
      mHold <= hN;
      mIdle <= iN;
      if (mMode == 0) mSleep <= (hN == 0);
      else mSleep <= mMiss && (iN >= mK) && (int'(missRemain) > mM);
      if (accessStrobe && mSleep) mWake <= WAKE_LAT;
      else if (mWake > 0) mWake <= mWake - 1;
      if (missStart) mMiss <= 1;
      else if (mMiss && missRemain == 0) mMiss <= 0;
      if (!mSleep) mMode <= modeSel;
      if (cfgWrite) begin
        case (cfgAddr)
          2'd0: mJ <= int'(cfgData);
          2'd1: mK <= int'(cfgData);
          2'd2: mM <= int'(cfgData);
          default: ;
        endcase
      end
    end
  end

  task automatic expect1(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic expectN(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock: sample away from the edge, compare with model, advance miss countdown
  task automatic cyc();
    @(posedge clk);
    #2;
    expect1(curTag, sleepOut, mSleep, "sleepOut vs model");
    expect1(curTag, wakePending, (mWake != 0), "wakePending vs model");
    if (missRemain != 0) missRemain = missRemain - 1'b1;
  endtask

  task automatic awakeLen(output int n, output logic wp);
    accessStrobe = 1; cyc(); accessStrobe = 0;
    wp = wakePending;
    n = 0;
    while (!sleepOut && n < 500) begin n++; cyc(); end
  endtask

  task automatic cfgSet(logic [1:0] a, int d);
    cfgWrite = 1; cfgAddr = a; cfgData = CNT_W'(d); cyc(); cfgWrite = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int n, st;
    logic wp;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    #1;
    // R1: reset state
    expect1("R1", sleepOut, 1'b1, "sleep after reset");
    expect1("R1", wakePending, 1'b0, "wakePending after reset");
    cyc();

    // R2 default hold window, R7 flag on waking access
    curTag = "R2";
    awakeLen(n, wp);
    expectN("R2", n, 8, "awake cycles with default hold");
    expect1("R7", wp, 1'b1, "wakePending after access while asleep");
    repeat (3) cyc();

    // R3 restart of window
    curTag = "R3";
    accessStrobe = 1; cyc(); accessStrobe = 0;
    repeat (4) cyc();
    awakeLen(n, wp);
    expectN("R3", n, 8, "window restarted by second access");
    expect1("R3", wp, 1'b0, "no wake flag while already awake");

    // R9 config writes
    curTag = "R9";
    cfgSet(2'd0, 3);
    awakeLen(n, wp);
    expectN("R9", n, 3, "hold window after write to address 0");
    cfgSet(2'd3, 1);
    awakeLen(n, wp);
    expectN("R9", n, 3, "address 3 leaves settings unchanged");

    // R8 mode request while asleep ignored
    curTag = "R8";
    modeSel = 1; repeat (5) cyc();
    modeSel = 0;
    awakeLen(n, wp);
    expectN("R8", n, 3, "policy unchanged by request made while asleep");

    // switch to stall policy while awake
    curTag = "R5";
    modeSel = 1;
    accessStrobe = 1; cyc(); accessStrobe = 0;
    repeat (6) cyc();
    expect1("R5", sleepOut, 1'b0, "stall policy awake without miss");

    // R4 sleep after idle threshold
    curTag = "R4";
    missStart = 1; missRemain = 40; cyc(); missStart = 0;
    n = 0;
    while (!sleepOut && n < 100) begin n++; cyc(); end
    expectN("R4", n, 10, "edges from miss start to sleep");

    // R5 early wake at lead time
    curTag = "R5";
    st = 0;
    while (sleepOut && st < 100) begin st = int'(missRemain); cyc(); end
    expectN("R5", st, 4, "remaining count sampled at wake edge");
    while (missRemain != 0) cyc();
    repeat (3) cyc();

    // R6 activity restarts idle count
    curTag = "R6";
    missStart = 1; missRemain = 60; cyc(); missStart = 0;
    repeat (5) cyc();
    issueActive = 1; cyc(); issueActive = 0;
    expect1("R6", sleepOut, 1'b0, "awake after issue activity");
    n = 0;
    while (!sleepOut && n < 100) begin n++; cyc(); end
    expectN("R6", n, 10, "idle edges after activity before sleep");

    // R7 access wakes in stall policy
    curTag = "R7";
    accessStrobe = 1; cyc(); accessStrobe = 0;
    expect1("R7", sleepOut, 1'b0, "access clears sleep in stall policy");
    expect1("R7", wakePending, 1'b1, "wake flag in stall policy");
    cyc();
    expect1("R7", wakePending, 1'b0, "wake flag lasts one cycle");
    while (missRemain != 0) cyc();

    // constrained random mix, all requirements checked against the model
    curTag = "R2 R3 R4 R5 R6 R7 R8 R9 random";
    begin
      bit busy = 0;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 19) == 0) busy = !busy;
        accessStrobe = ($urandom_range(0, 11) == 0);
        issueActive = busy && $urandom_range(0, 1);
        execActive = busy && ($urandom_range(0, 3) == 0);
        if ($urandom_range(0, 49) == 0) modeSel = !modeSel;
        cfgWrite = ($urandom_range(0, 99) == 0);
        cfgAddr = 2'($urandom_range(0, 3));
        cfgData = CNT_W'($urandom_range(1, 15));
        missStart = 0;
        if (missRemain == 0 && $urandom_range(0, 9) == 0) begin
          missStart = 1;
          missRemain = CNT_W'($urandom_range(5, 40));
        end
        cyc();
      end
    end
    accessStrobe = 0; issueActive = 0; execActive = 0; cfgWrite = 0; missStart = 0;
    finished = 1;
    summary();
  end
endmodule